// File: doc/BRIEF.md
# Jittered Switching-Cycle Oscillator

This block derives the timing of a fixed-frequency switching converter from a fast system clock. It marks the start of every switching cycle with a one-clock strobe and produces a maximum-duty window. The window opens at the cycle start and closes at a fixed fraction of that cycle's length. With the default parameters and a 125 MHz system clock, the average cycle rate is 277 kHz.

To spread conducted emissions, the cycle length is swept slowly along a triangle. At every cycle boundary a stepper supplies a signed offset, and the reload value of the period counter is the nominal count plus that offset. The defaults are a depth of 13 counts and 5 cycles per step. This sweeps the rate between roughly 269 kHz and 285 kHz, and the sweep repeats about every 260 cycles, close to 1.1 kHz. When the enable input is low, the period returns to the nominal count and the sweep pauses where it stands. Each cycle recomputes its duty limit from its own length.

Top module: `spread_osc`

## Requirements
- R1: While `rst_n` is low, `clk_pulse` and `dcmax` are low. After `rst_n` rises, the first `clk_pulse` appears after the third rising clock edge. The two edges before it are taken by a 2-stage reset synchronizer.
- R2: `clk_pulse` is high for exactly one system clock per switching cycle. The cycle length is the number of clocks from one `clk_pulse` to the next.
- R3: When `jit_en` was high at the edge that started a cycle, that cycle lasts NOM_RELOAD + offset clocks. The offset starts at 0 after reset and moves toward +JIT_DEPTH first. It changes by one after every JIT_HOLD enabled cycles and reverses on reaching +JIT_DEPTH or -JIT_DEPTH, so each extreme is held for JIT_HOLD cycles and then left.
- R4: When `jit_en` was low at the edge that started a cycle, that cycle lasts exactly NOM_RELOAD clocks and the offset does not advance. A later enabled cycle resumes the sweep from the held position.
- R5: `jit_en` is looked at only on the clock edge that starts a cycle. Toggling it inside a cycle, and restoring it before the cycle ends, has no effect on any cycle length.
- R6: `dcmax` is high from the `clk_pulse` clock onward for a contiguous floor(P × DUTY_NUM / 2^DUTY_SH) clocks, where P is that cycle's length. It is low for the rest of the cycle and rises only together with `clk_pulse`.
- R7: Every cycle length lies within NOM_RELOAD − JIT_DEPTH to NOM_RELOAD + JIT_DEPTH.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| jit_en | input | 1 | Enables the triangular period sweep when high |
| clk_pulse | output | 1 | One-clock strobe at each switching-cycle start |
| dcmax | output | 1 | Maximum on-time window of the current cycle |

## Verification
The bench builds the block with a nominal count of 40, a depth of 4, 2 cycles per step and the default duty ratio of 166/256. A full triangle sweep is then 32 cycles, and each cycle is about 40 clocks. A few thousand clocks therefore take the sweep through both turning points several times, through pauses of the sweep, and through mid-cycle toggles of the enable. The short cycles also keep every duty-window boundary, at 23 to 28 clocks, easy to count exactly.

// File: rtl/spread_osc_pkg.sv
package spread_osc_pkg;

  // Direction of the triangular period offset.
  typedef enum logic {
    SWEEP_UP   = 1'b0,
    SWEEP_DOWN = 1'b1
  } sweep_dir_e;

  // Bits needed to hold a signed offset of +/- depth.
  function automatic int ofs_width(input int depth);
    return $clog2(depth + 1) + 1;
  endfunction

endpackage

// File: rtl/spread_rst_sync.sv
module spread_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/spread_tri.sv
module spread_tri
  import spread_osc_pkg::*;
#(
  parameter  int DEPTH  = 13,
  parameter  int HOLD   = 5,
  localparam int OFS_W  = ofs_width(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    adv,
  output logic signed [OFS_W-1:0] ofs
);

  localparam int HOLD_W = (HOLD > 1) ? $clog2(HOLD) : 1;
  localparam logic signed [OFS_W-1:0] TOP = OFS_W'(DEPTH);
  localparam logic signed [OFS_W-1:0] BOT = -TOP;

  generate
    if (DEPTH == 0) begin : g_flat
      assign ofs = '0;
    end else begin : g_sweep
      logic signed [OFS_W-1:0] ofs_q, ofs_d;
      sweep_dir_e              dir_q, dir_d;
      logic [HOLD_W-1:0]       hold_q, hold_d;

      always_comb begin
        ofs_d  = ofs_q;
        dir_d  = dir_q;
        hold_d = hold_q;
        if (adv) begin
          if (hold_q == HOLD_W'(HOLD - 1)) begin
            hold_d = '0;
            if (dir_q == SWEEP_UP) begin
              if (ofs_q == TOP) begin
                dir_d = SWEEP_DOWN;
                ofs_d = ofs_q - OFS_W'(1);
              end else begin
                ofs_d = ofs_q + OFS_W'(1);
              end
            end else begin
              if (ofs_q == BOT) begin
                dir_d = SWEEP_UP;
                ofs_d = ofs_q + OFS_W'(1);
              end else begin
                ofs_d = ofs_q - OFS_W'(1);
              end
            end
          end else begin
            hold_d = hold_q + HOLD_W'(1);
          end
        end
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          ofs_q  <= '0;
          dir_q  <= SWEEP_UP;
          hold_q <= '0;
        end else if (adv) begin
          ofs_q  <= ofs_d;
          dir_q  <= dir_d;
          hold_q <= hold_d;
        end
      end

      assign ofs = ofs_q;

      // R7: offset never leaves the sweep band
      assert_ofs_in_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ofs_q <= TOP) && (ofs_q >= BOT));
      // R4: without an advance request the offset holds
      assert_ofs_frozen_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !adv |=> $stable(ofs_q));
    end
  endgenerate

endmodule

// File: rtl/spread_period.sv
module spread_period #(
  parameter  int NOM   = 451,
  parameter  int DEPTH = 13,
  parameter  int OFS_W = 5,
  localparam int PER_W = $clog2(NOM + DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    jit_en,
  input  logic signed [OFS_W-1:0] ofs,
  output logic                    wrap,
  output logic                    start,
  output logic [PER_W-1:0]        cnt,
  output logic [PER_W-1:0]        next_per
);

  logic [PER_W-1:0] cnt_q, cnt_d;
  logic [PER_W-1:0] per_q, per_d;
  logic             start_q;
  logic [PER_W-1:0] per_load;

  always_comb begin
    wrap     = (cnt_q == per_q - PER_W'(1));
    per_load = jit_en ? PER_W'(NOM + int'(ofs)) : PER_W'(NOM);
    cnt_d    = wrap ? '0 : cnt_q + PER_W'(1);
    per_d    = wrap ? per_load : per_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= PER_W'(NOM - 1);
      per_q   <= PER_W'(NOM);
      start_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      per_q   <= per_d;
      start_q <= wrap;
    end
  end

  assign start    = start_q;
  assign cnt      = cnt_q;
  assign next_per = per_load;

  // R7: the active period stays in the band
  assert_per_in_band_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (per_q >= PER_W'(NOM - DEPTH)) && (per_q <= PER_W'(NOM + DEPTH)));
  // R4: a boundary seen with jitter off loads the nominal period
  assert_nominal_when_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wrap && !jit_en) |=> (per_q == PER_W'(NOM)));
  // R2: cycle-start strobe lasts one clock
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_q |=> !start_q);

endmodule

// File: rtl/spread_duty.sv
module spread_duty #(
  parameter  int PER_W    = 9,
  parameter  int DUTY_NUM = 166,
  parameter  int DUTY_SH  = 8,
  localparam int NUM_W    = $clog2(DUTY_NUM + 1),
  localparam int PROD_W   = PER_W + NUM_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wrap,
  input  logic [PER_W-1:0] next_per,
  input  logic [PER_W-1:0] cnt,
  output logic             dcmax
);

  logic [PER_W-1:0]  lim_q, lim_d;
  logic              dc_q, dc_d;
  logic [PROD_W-1:0] prod;
  logic [PER_W-1:0]  lim_load;
  logic [PER_W:0]    cnt_nx;

  always_comb begin
    prod     = PROD_W'(next_per) * PROD_W'(DUTY_NUM);
    lim_load = PER_W'(prod >> DUTY_SH);
    cnt_nx   = {1'b0, cnt} + (PER_W + 1)'(1);
    lim_d    = wrap ? lim_load : lim_q;
    dc_d     = wrap ? (lim_load != '0) : (cnt_nx < {1'b0, lim_q});
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lim_q <= '0;
      dc_q  <= 1'b0;
    end else begin
      lim_q <= lim_d;
      dc_q  <= dc_d;
    end
  end

  assign dcmax = dc_q;

  // R6: window can only open at a cycle boundary
  assert_window_opens_at_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!dc_q && !wrap) |=> !dc_q);

endmodule

// File: rtl/spread_osc.sv
module spread_osc
  import spread_osc_pkg::*;
#(
  parameter int NOM_RELOAD = 451,
  parameter int JIT_DEPTH  = 13,
  parameter int JIT_HOLD   = 5,
  parameter int DUTY_NUM   = 166,
  parameter int DUTY_SH    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic jit_en,
  output logic clk_pulse,
  output logic dcmax
);

  localparam int OFS_W = ofs_width(JIT_DEPTH);
  localparam int PER_W = $clog2(NOM_RELOAD + JIT_DEPTH + 1);

  logic                    rst_s_n;
  logic                    wrap;
  logic                    tri_adv;
  logic signed [OFS_W-1:0] ofs;
  logic [PER_W-1:0]        cnt;
  logic [PER_W-1:0]        next_per;

  spread_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_s_n)
  );

  assign tri_adv = wrap & jit_en;

  spread_tri #(.DEPTH(JIT_DEPTH), .HOLD(JIT_HOLD)) u_tri (
    .clk   (clk),
    .rst_n (rst_s_n),
    .adv   (tri_adv),
    .ofs   (ofs)
  );

  spread_period #(.NOM(NOM_RELOAD), .DEPTH(JIT_DEPTH), .OFS_W(OFS_W)) u_per (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .jit_en   (jit_en),
    .ofs      (ofs),
    .wrap     (wrap),
    .start    (clk_pulse),
    .cnt      (cnt),
    .next_per (next_per)
  );

  spread_duty #(.PER_W(PER_W), .DUTY_NUM(DUTY_NUM), .DUTY_SH(DUTY_SH)) u_duty (
    .clk      (clk),
    .rst_n    (rst_s_n),
    .wrap     (wrap),
    .next_per (next_per),
    .cnt      (cnt),
    .dcmax    (dcmax)
  );

  // R6: the window is open on the cycle-start clock
  assert_dcmax_at_start_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    clk_pulse |-> dcmax);
  // R6: the window rises only with the strobe
  assert_dcmax_rise_with_pulse_R6: assert property (@(posedge clk) disable iff (!rst_s_n)
    $rose(dcmax) |-> clk_pulse);
  // R1: outputs quiet while held in reset
  assert_quiet_in_reset_R1: assert property (@(posedge clk)
    !rst_s_n |-> (!clk_pulse && !dcmax));

endmodule

// File: tb/test_spread_osc.sv
module test_spread_osc;

  localparam int P_NOM  = 40;
  localparam int P_DEP  = 4;
  localparam int P_HOLD = 2;
  localparam int P_NUM  = 166;
  localparam int P_SH   = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic jit_en;
  logic clk_pulse;
  logic dcmax;

  int n_cmp = 0;
  int n_bad = 0;
  bit done  = 1'b0;

  int m_ofs = 0;
  int m_dir = 0;
  int m_h   = 0;
  bit en_used;

  always #4 clk = ~clk;

  spread_osc #(
    .NOM_RELOAD (P_NOM),
    .JIT_DEPTH  (P_DEP),
    .JIT_HOLD   (P_HOLD),
    .DUTY_NUM   (P_NUM),
    .DUTY_SH    (P_SH)
  ) i_spread_osc (
    .clk       (clk),
    .rst_n     (rst_n),
    .jit_en    (jit_en),
    .clk_pulse (clk_pulse),
    .dcmax     (dcmax)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int duty_exp(input int p);
    return (p * P_NUM) >> P_SH;
  endfunction

  task automatic model_adv();
    if (m_h == P_HOLD - 1) begin
      m_h = 0;
      if (m_dir == 0) begin
        if (m_ofs == P_DEP) begin m_dir = 1; m_ofs--; end
        else m_ofs++;
      end else begin
        if (m_ofs == -P_DEP) begin m_dir = 0; m_ofs++; end
        else m_ofs--;
      end
    end else begin
      m_h++;
    end
  endtask

  // Called at the negedge on which clk_pulse is seen high.
  task automatic run_cycle(input bit new_en, input bit glitch);
    int    exp_len;
    int    len;
    int    hi;
    bit    fell;
    bit    shape_bad;
    string tag;
    exp_len = en_used ? P_NOM + m_ofs : P_NOM;
    tag     = glitch ? "R5" : (en_used ? "R3" : "R4");
    if (en_used) model_adv();
    chk(dcmax == 1'b1, "R6 window open at start", int'(dcmax), 1);
    jit_en    = new_en;
    len       = 1;
    hi        = dcmax ? 1 : 0;
    fell      = 1'b0;
    shape_bad = 1'b0;
    forever begin
      @(negedge clk);
      if (clk_pulse || len > 2000) break;
      len++;
      if (glitch && len == 4) jit_en = !new_en;
      if (glitch && len == 6) jit_en = new_en;
      if (dcmax) begin
        if (fell) shape_bad = 1'b1;
        hi++;
      end else begin
        fell = 1'b1;
      end
    end
    chk(len == exp_len, tag, len, exp_len);
    chk(len > 1, "R2 single-clock strobe", len, exp_len);
    chk(hi == duty_exp(exp_len), "R6 window length", hi, duty_exp(exp_len));
    chk(!shape_bad, "R6 window contiguous", int'(shape_bad), 0);
    chk(len >= P_NOM - P_DEP && len <= P_NOM + P_DEP, "R7 band", len, P_NOM);
    en_used = new_en;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20061));
    jit_en = 1'b1;
    rst_n  = 1'b0;
    repeat (3) begin
      @(negedge clk);
      chk(!clk_pulse && !dcmax, "R1 quiet in reset", int'(clk_pulse | dcmax), 0);
    end
    rst_n = 1'b1;
    @(negedge clk);
    chk(!clk_pulse, "R1 edge 1", int'(clk_pulse), 0);
    @(negedge clk);
    chk(!clk_pulse, "R1 edge 2", int'(clk_pulse), 0);
    @(negedge clk);
    chk(clk_pulse, "R1 first strobe", int'(clk_pulse), 1);
    en_used = 1'b1;

    // R3: full sweeps through both turning points
    for (int i = 0; i < 40; i++) run_cycle(1'b1, 1'b0);
    // R4: sweep paused at nominal
    for (int i = 0; i < 6; i++) run_cycle(1'b0, 1'b0);
    // R4: resume from held position
    for (int i = 0; i < 10; i++) run_cycle(1'b1, 1'b0);
    // R5: mid-cycle toggles, both polarities
    for (int i = 0; i < 4; i++) run_cycle(1'b1, 1'b1);
    for (int i = 0; i < 3; i++) run_cycle(1'b0, 1'b1);
    for (int i = 0; i < 3; i++) run_cycle(1'b1, 1'b1);
    // mixed random stimulus
    for (int i = 0; i < 120; i++) begin
      bit en_r;
      bit gl_r;
      en_r = ($urandom % 4) != 0;
      gl_r = ($urandom % 5) == 0;
      run_cycle(en_r, gl_r);
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule